// File: doc/BRIEF.md
# Teletext Page Memory Register Interface

This block is the host-side register file of a teletext decoder. It sits behind a byte-level serial-bus front end, which has already removed bit framing. The front end signals a transaction start, then delivers bytes. After a start, the first byte sets the register sub-address. Each byte after that is written to the current sub-address. The sub-address then advances, except at the memory data port.

The block holds eleven write-only control registers. These cover acquisition and sync modes, page-request addressing and data, the displayed chapter, two display-control sets, display mode, the active chapter with its VPS enable, and the row and column pointers. Sub-address 0x0B gives indirect access to an 8-chapter character store of 26 rows by 40 columns. Chapter, row and column pointers select the byte. The column pointer advances after every data access, so whole rows stream through a single address.

A mode bit lets reads at 0x0B return a status byte instead of memory data. The status byte is built from external quality and field-rate signals. A fill engine presets the store after reset and can clear one chapter on request. While the engine runs, `busy_o` is high and the block discards all host traffic.

Top module: `ttx_regif`

## Requirements
- R1: After reset, every register bit reads 0, except bits 1..0 of both display-control registers (sub-addresses 5 and 6), which read 1.
- R2: Reserved bits are stored as 0 whatever is written. Writing 0xFF stores these values: sub 0 gives 0xD5; subs 1 and 2 give 0x7F; sub 3 gives 0x1F; sub 4 gives 0x07; subs 5, 6 and 7 give 0xFF. Sub 8 keeps only bit 4 (VPS enable) and bits 2..0 (chapter). Sub 9 keeps 5 bits and sub 10 keeps 6 bits.
- R3: After `start_i`, the first byte is taken as the sub-address. Later bytes go to consecutive sub-addresses, and the address stops advancing at 0x0B.
- R4: From reset release, `busy_o` stays high for exactly 8320 cycles. After that, every stored byte is 0x20, except chapter 0, row 0, column 7, which is 0x07.
- R5: A byte written at 0x0B lands at the (chapter, row, column) of sub 8 bits 2..0, sub 9 and sub 10. A read request at 0x0B returns that byte with `rd_valid_o` one cycle later.
- R6: After each memory data access, the column pointer advances. Column 39 or above goes to column 0 and advances the row. Row 25 or above goes to row 0.
- R7: When sub 0 bit 0 is 1, a read at 0x0B returns {bit7 = 60 Hz flag, bits 6..2 = 0, bit1 = data quality, bit0 = sync quality} and leaves the pointers unchanged. A write at 0x0B still updates memory.
- R8: Writing sub 8 with bit 3 set fills the newly selected chapter with 0x20. `busy_o` is high for exactly 1040 cycles. Other chapters are untouched, and bit 3 is not retained.
- R9: While `busy_o` is high, starts, bytes and read requests are ignored. No register changes and `rd_valid_o` stays low.
- R10: A read request at any sub-address other than 0x0B returns 0x00 with `rd_valid_o`.
- R11: When the row is above 25 or the column is above 39, memory writes are dropped and reads return 0x00. No other location is altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Transaction start pulse |
| wr_valid_i | input | 1 | Host byte valid |
| wr_data_i | input | 8 | Host byte |
| rd_req_i | input | 1 | Read request pulse |
| sync_good_i | input | 1 | Composite sync quality good |
| data_good_i | input | 1 | Teletext data quality good |
| field_60hz_i | input | 1 | Field rate is 60 Hz |
| rd_data_o | output | 8 | Read byte |
| rd_valid_o | output | 1 | Read byte valid |
| busy_o | output | 1 | Fill engine running |
| mode0_o | output | 8 | Register sub 0 |
| mode1_o | output | 8 | Register sub 1 |
| preq_addr_o | output | 8 | Register sub 2 |
| preq_data_o | output | 5 | Register sub 3 |
| disp_chap_o | output | 3 | Displayed chapter (sub 4) |
| disp_norm_o | output | 8 | Display control, normal (sub 5) |
| disp_news_o | output | 8 | Display control, flash/subtitle (sub 6) |
| disp_mode_o | output | 8 | Display mode (sub 7) |
| vps_en_o | output | 1 | VPS acquisition enable (sub 8 bit 4) |
| act_chap_o | output | 3 | Active chapter |
| act_row_o | output | 5 | Row pointer |
| act_col_o | output | 6 | Column pointer |

## Verification
The hardest case to reach is host traffic that arrives while the chapter clear is running. That traffic must vanish without trace, and the clear must still last exactly one chapter. The stimulus triggers a clear and, in the cycles right after, sends a start, a register write and a read request. It then counts the remaining busy cycles and checks that the displayed-chapter register is unchanged. Pointer wrap is driven by streaming whole chapters with a single pointer setup. Out-of-range pointers are written next to a location they would alias onto, and that location is then read back.

// File: rtl/ttx_pkg.sv
package ttx_pkg;
  localparam int CHAP_N = 8;
  localparam int ROW_N  = 26;
  localparam int COL_N  = 40;
  localparam int DW     = 8;
  localparam int NREG   = 11;
  localparam logic [7:0] SUB_DATA = 8'h0B;
  localparam int IDX_MODE0 = 0;
  localparam int IDX_ACT   = 8;
  localparam int IDX_ROW   = 9;
  localparam int IDX_COL   = 10;

  typedef enum logic [1:0] {RD_NONE, RD_MEM, RD_STAT, RD_ZERO} rd_src_e;

  function automatic logic [7:0] reg_mask(input int idx);
    case (idx)
      0:       return 8'hD5;
      1, 2:    return 8'h7F;
      3:       return 8'h1F;
      4:       return 8'h07;
      8:       return 8'h17;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] reg_rst(input int idx);
    return (idx == 5 || idx == 6) ? 8'h03 : 8'h00;
  endfunction
endpackage

// File: rtl/ttx_host_seq.sv
module ttx_host_seq
  import ttx_pkg::*;
#(
  parameter int NR = NREG
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       busy_i,
  input  logic       sel_stat_i,
  input  logic       start_i,
  input  logic       wr_valid_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_req_i,
  output logic       reg_we_o,
  output logic [3:0] reg_idx_o,
  output logic [7:0] reg_wdata_o,
  output logic       mem_we_o,
  output logic       mem_re_o,
  output logic       stat_re_o,
  output logic       zero_re_o
);
  localparam logic [7:0] NR_B = 8'(NR);

  logic       expect_sub_q;
  logic [7:0] sub_q;
  logic       byte_ok, rd_ok, at_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      expect_sub_q <= 1'b1;
      sub_q        <= '0;
    end else if (!busy_i) begin
      if (start_i) expect_sub_q <= 1'b1;
      else if (wr_valid_i) begin
        if (expect_sub_q) begin
          sub_q        <= wr_data_i;
          expect_sub_q <= 1'b0;
        end else if (sub_q != SUB_DATA) begin
          sub_q <= sub_q + 8'd1;
        end
      end
    end
  end

  always_comb begin
    at_data     = (sub_q == SUB_DATA);
    byte_ok     = !busy_i && !start_i && wr_valid_i && !expect_sub_q;
    rd_ok       = !busy_i && rd_req_i;
    reg_we_o    = byte_ok && (sub_q < NR_B);
    reg_idx_o   = sub_q[3:0];
    reg_wdata_o = wr_data_i;
    mem_we_o    = byte_ok && at_data;
    stat_re_o   = rd_ok && at_data && sel_stat_i;
    mem_re_o    = rd_ok && at_data && !sel_stat_i;
    zero_re_o   = rd_ok && !at_data;
  end

  assert_busy_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(sub_q) && $stable(expect_sub_q));
endmodule

// File: rtl/ttx_ctrl_regs.sv
module ttx_ctrl_regs
  import ttx_pkg::*;
#(
  parameter int NR    = NREG,
  parameter int ROW_W = 5,
  parameter int COL_W = 6,
  parameter int RN    = ROW_N,
  parameter int CN    = COL_N,
  parameter int CW    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [3:0]          reg_idx_i,
  input  logic [7:0]          reg_wdata_i,
  input  logic                adv_i,
  output logic [NR-1:0][7:0]  regs_o,
  output logic [ROW_W-1:0]    row_o,
  output logic [COL_W-1:0]    col_o,
  output logic                clr_go_o,
  output logic [CW-1:0]       clr_chap_o
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(RN - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(CN - 1);

  logic [NR-1:0][7:0]  regs_q;
  logic                col_wrap;
  logic [ROW_W-1:0]    row_nxt;
  logic [COL_W-1:0]    col_nxt;

  assign row_o = regs_q[IDX_ROW][ROW_W-1:0];
  assign col_o = regs_q[IDX_COL][COL_W-1:0];

  always_comb begin
    col_wrap = (col_o >= COL_LAST);
    col_nxt  = col_wrap ? '0 : col_o + 1'b1;
    if (!col_wrap)              row_nxt = row_o;
    else if (row_o >= ROW_LAST) row_nxt = '0;
    else                        row_nxt = row_o + 1'b1;
  end

  for (genvar i = 0; i < NR; i++) begin : g_reg
    localparam logic [7:0] MASK = (i == IDX_ROW) ? 8'((1 << ROW_W) - 1) :
                                  (i == IDX_COL) ? 8'((1 << COL_W) - 1) : reg_mask(i);
    logic hit;
    assign hit = reg_we_i && (reg_idx_i == 4'(i));
    if (i == IDX_ROW) begin : g_row
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     regs_q[i] <= reg_rst(i);
        else if (hit)    regs_q[i] <= reg_wdata_i & MASK;
        else if (adv_i)  regs_q[i] <= {{(8-ROW_W){1'b0}}, row_nxt};
      end
    end else if (i == IDX_COL) begin : g_col
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     regs_q[i] <= reg_rst(i);
        else if (hit)    regs_q[i] <= reg_wdata_i & MASK;
        else if (adv_i)  regs_q[i] <= {{(8-COL_W){1'b0}}, col_nxt};
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     regs_q[i] <= reg_rst(i);
        else if (hit)    regs_q[i] <= reg_wdata_i & MASK;
      end
    end
  end

  assign regs_o     = regs_q;
  assign clr_go_o   = reg_we_i && (reg_idx_i == 4'(IDX_ACT)) && reg_wdata_i[3];
  assign clr_chap_o = reg_wdata_i[CW-1:0];

  assert_col_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !reg_we_i) |=> (col_o == ($past(col_o) >= COL_LAST ? '0 : $past(col_o) + 1'b1)));
  assert_sel_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_idx_i == 4'(IDX_MODE0)) |=> $stable(regs_q[IDX_MODE0]));
  assert_clr_not_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_go_o |=> !regs_q[IDX_ACT][3]);
endmodule

// File: rtl/ttx_page_mem.sv
module ttx_page_mem
  import ttx_pkg::*;
#(
  parameter int CHN = CHAP_N,
  parameter int RN  = ROW_N,
  parameter int CN  = COL_N,
  parameter int W   = DW,
  parameter int PRESET_IDX = 7,
  localparam int CW   = $clog2(CHN),
  localparam int RW   = $clog2(RN),
  localparam int COLW = $clog2(CN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CW-1:0]   chap_i,
  input  logic [RW-1:0]   row_i,
  input  logic [COLW-1:0] col_i,
  input  logic            we_i,
  input  logic [W-1:0]    wdata_i,
  input  logic            re_i,
  input  logic            clr_go_i,
  input  logic [CW-1:0]   clr_chap_i,
  output logic [W-1:0]    rdata_o,
  output logic            busy_o
);
  localparam int CHAP_SZ = RN * CN;
  localparam int DEPTH   = CHN * CHAP_SZ;
  localparam int AW      = $clog2(DEPTH);
  localparam logic [W-1:0] BLANK = W'(8'h20);
  localparam logic [W-1:0] PRE_V = W'(8'h07);

  logic [W-1:0]  mem [DEPTH];
  logic          fill_on_q, fill_init_q;
  logic [AW-1:0] fill_ptr_q, fill_end_q, addr, clr_base;
  logic [W-1:0]  fill_val, rdata_q;
  logic          in_range;

  always_comb begin
    in_range = (row_i < RW'(RN)) && (col_i < COLW'(CN));
    addr     = AW'(chap_i) * AW'(CHAP_SZ) + AW'(row_i) * AW'(CN) + AW'(col_i);
    clr_base = AW'(clr_chap_i) * AW'(CHAP_SZ);
    fill_val = (fill_init_q && fill_ptr_q == AW'(PRESET_IDX)) ? PRE_V : BLANK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_on_q   <= 1'b1;
      fill_init_q <= 1'b1;
      fill_ptr_q  <= '0;
      fill_end_q  <= AW'(DEPTH - 1);
    end else if (fill_on_q) begin
      fill_ptr_q <= fill_ptr_q + 1'b1;
      if (fill_ptr_q == fill_end_q) begin
        fill_on_q   <= 1'b0;
        fill_init_q <= 1'b0;
      end
    end else if (clr_go_i) begin
      fill_on_q  <= 1'b1;
      fill_ptr_q <= clr_base;
      fill_end_q <= clr_base + AW'(CHAP_SZ - 1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_on_q)              mem[fill_ptr_q] <= fill_val;
    else if (we_i && in_range)  mem[addr]       <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= in_range ? mem[addr] : '0;
  end

  assign rdata_o = rdata_q;
  assign busy_o  = fill_on_q;

  logic [AW:0] chk_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        chk_cnt_q <= '0;
    else if (fill_on_q) chk_cnt_q <= chk_cnt_q + 1'b1;
    else                chk_cnt_q <= '0;
  end

  assert_fill_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fill_on_q) |-> (chk_cnt_q == (AW+1)'(CHAP_SZ) || chk_cnt_q == (AW+1)'(DEPTH)));
  assert_fill_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fill_on_q) |-> $past(clr_go_i));
  assert_no_host_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_on_q |-> !we_i && !re_i && !clr_go_i);
endmodule

// File: rtl/ttx_regif.sv
module ttx_regif
  import ttx_pkg::*;
#(
  parameter int CHN = CHAP_N,
  parameter int RN  = ROW_N,
  parameter int CN  = COL_N,
  localparam int CW   = $clog2(CHN),
  localparam int RW   = $clog2(RN),
  localparam int COLW = $clog2(CN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            wr_valid_i,
  input  logic [7:0]      wr_data_i,
  input  logic            rd_req_i,
  input  logic            sync_good_i,
  input  logic            data_good_i,
  input  logic            field_60hz_i,
  output logic [7:0]      rd_data_o,
  output logic            rd_valid_o,
  output logic            busy_o,
  output logic [7:0]      mode0_o,
  output logic [7:0]      mode1_o,
  output logic [7:0]      preq_addr_o,
  output logic [4:0]      preq_data_o,
  output logic [2:0]      disp_chap_o,
  output logic [7:0]      disp_norm_o,
  output logic [7:0]      disp_news_o,
  output logic [7:0]      disp_mode_o,
  output logic            vps_en_o,
  output logic [CW-1:0]   act_chap_o,
  output logic [RW-1:0]   act_row_o,
  output logic [COLW-1:0] act_col_o
);
  logic [NREG-1:0][7:0] regs;
  logic        reg_we, mem_we, mem_re, stat_re, zero_re, clr_go, busy;
  logic [3:0]  reg_idx;
  logic [7:0]  reg_wdata, mem_rdata, stat_q;
  logic [CW-1:0] clr_chap;
  rd_src_e     rd_src_q;

  ttx_host_seq #(.NR(NREG)) u_seq (
    .clk_i, .rst_ni, .busy_i(busy), .sel_stat_i(regs[IDX_MODE0][0]),
    .start_i, .wr_valid_i, .wr_data_i, .rd_req_i,
    .reg_we_o(reg_we), .reg_idx_o(reg_idx), .reg_wdata_o(reg_wdata),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .stat_re_o(stat_re), .zero_re_o(zero_re)
  );

  ttx_ctrl_regs #(.NR(NREG), .ROW_W(RW), .COL_W(COLW), .RN(RN), .CN(CN), .CW(CW)) u_regs (
    .clk_i, .rst_ni, .reg_we_i(reg_we), .reg_idx_i(reg_idx), .reg_wdata_i(reg_wdata),
    .adv_i(mem_we || mem_re), .regs_o(regs), .row_o(act_row_o), .col_o(act_col_o),
    .clr_go_o(clr_go), .clr_chap_o(clr_chap)
  );

  ttx_page_mem #(.CHN(CHN), .RN(RN), .CN(CN), .W(8)) u_mem (
    .clk_i, .rst_ni, .chap_i(act_chap_o), .row_i(act_row_o), .col_i(act_col_o),
    .we_i(mem_we), .wdata_i(reg_wdata), .re_i(mem_re),
    .clr_go_i(clr_go), .clr_chap_i(clr_chap), .rdata_o(mem_rdata), .busy_o(busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_src_q <= RD_NONE;
      stat_q   <= '0;
    end else begin
      if (stat_re)      rd_src_q <= RD_STAT;
      else if (mem_re)  rd_src_q <= RD_MEM;
      else if (zero_re) rd_src_q <= RD_ZERO;
      else              rd_src_q <= RD_NONE;
      if (stat_re) stat_q <= {field_60hz_i, 5'b0, data_good_i, sync_good_i};
    end
  end

  always_comb begin
    rd_valid_o = (rd_src_q != RD_NONE);
    case (rd_src_q)
      RD_MEM:  rd_data_o = mem_rdata;
      RD_STAT: rd_data_o = stat_q;
      default: rd_data_o = 8'h00;
    endcase
  end

  assign busy_o      = busy;
  assign mode0_o     = regs[0];
  assign mode1_o     = regs[1];
  assign preq_addr_o = regs[2];
  assign preq_data_o = regs[3][4:0];
  assign disp_chap_o = regs[4][2:0];
  assign disp_norm_o = regs[5];
  assign disp_news_o = regs[6];
  assign disp_mode_o = regs[7];
  assign vps_en_o    = regs[IDX_ACT][4];
  assign act_chap_o  = regs[IDX_ACT][CW-1:0];

  logic unused_bits;
  assign unused_bits = ^{regs[3][7:5], regs[4][7:3], regs[IDX_ACT][7:5], regs[IDX_ACT][3],
                         regs[IDX_ROW], regs[IDX_COL]};

  assert_rd_follows_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_req_i));
  assert_stat_no_move_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_re |=> $stable(act_col_o) && $stable(act_row_o));
endmodule

// File: tb/ttx_regif_tb.sv
module ttx_regif_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, wr_valid = 0, rd_req = 0, sync_ok = 0, data_ok = 0, hz60 = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data, mode0, mode1, preq_addr, disp_norm, disp_news, disp_mode;
  logic [4:0] preq_data, act_row;
  logic [2:0] disp_chap, act_chap;
  logic [5:0] act_col;
  logic rd_valid, busy, vps_en;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  ttx_regif u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .rd_req_i(rd_req), .sync_good_i(sync_ok), .data_good_i(data_ok), .field_60hz_i(hz60),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .busy_o(busy), .mode0_o(mode0), .mode1_o(mode1),
    .preq_addr_o(preq_addr), .preq_data_o(preq_data), .disp_chap_o(disp_chap),
    .disp_norm_o(disp_norm), .disp_news_o(disp_news), .disp_mode_o(disp_mode),
    .vps_en_o(vps_en), .act_chap_o(act_chap), .act_row_o(act_row), .act_col_o(act_col)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic t_start();
    start = 1; @(negedge clk); start = 0;
  endtask
  task automatic t_byte(input logic [7:0] d);
    wr_valid = 1; wr_data = d; @(negedge clk); wr_valid = 0;
  endtask
  task automatic t_read(output logic [7:0] d, output logic v);
    rd_req = 1; @(negedge clk); rd_req = 0; d = rd_data; v = rd_valid;
  endtask
  task automatic t_point(input int c, input int r, input int col);
    t_start(); t_byte(8'h08); t_byte(8'(c)); t_byte(8'(r)); t_byte(8'(col));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d; logic v; int cnt; int ok;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    chk("R1 mode0", mode0, 0); chk("R1 mode1", mode1, 0); chk("R1 preq_addr", preq_addr, 0);
    chk("R1 preq_data", preq_data, 0); chk("R1 disp_chap", disp_chap, 0);
    chk("R1 disp_norm", disp_norm, 8'h03); chk("R1 disp_news", disp_news, 8'h03);
    chk("R1 disp_mode", disp_mode, 0); chk("R1 vps", vps_en, 0);
    chk("R1 ptrs", {act_chap, act_row, act_col}, 0);
    // R4 preset duration
    cnt = 0;
    while (busy && cnt < 20000) begin cnt++; @(negedge clk); end
    chk("R4 init busy cycles", cnt, 8320);

    // R4 / R6 sweep of all chapters through the data port
    for (int ch = 0; ch < 8; ch++) begin
      t_point(ch, 0, 0);
      ok = 1;
      for (int i = 0; i < 1040; i++) begin
        t_read(d, v);
        chk("R4 preset byte", {v, d}, {1'b1, ((ch == 0 && i == 7) ? 8'h07 : 8'h20)});
      end
      chk("R6 row/col wrap to origin", {act_row, act_col}, 0);
    end

    // R2 / R3 masks via auto-increment
    t_start(); t_byte(8'h00);
    for (int k = 0; k < 8; k++) t_byte(8'hFF);
    chk("R2 sub0", mode0, 8'hD5); chk("R2 sub1", mode1, 8'h7F);
    chk("R2 sub2", preq_addr, 8'h7F); chk("R2 sub3", preq_data, 5'h1F);
    chk("R3 sub4", disp_chap, 7); chk("R3 sub5", disp_norm, 8'hFF);
    chk("R3 sub6", disp_news, 8'hFF); chk("R3 sub7", disp_mode, 8'hFF);
    t_start(); t_byte(8'h08); t_byte(8'hF7); t_byte(8'hFF); t_byte(8'hFF);
    chk("R2 sub8", {vps_en, act_chap}, 4'hF); chk("R2 sub9", act_row, 31);
    chk("R2 sub10", act_col, 63); chk("R2 no clear", busy, 0);
    // R11 write at row 31 col 63 dropped; pointer wraps (R6)
    t_byte(8'h55);
    chk("R6 wrap out of range", {act_row, act_col}, 0);
    t_start(); t_byte(8'h00); t_byte(8'h00);
    t_point(6, 30, 0); t_byte(8'h55);
    t_point(6, 30, 0); t_read(d, v);
    chk("R11 oob read", {v, d}, {1'b1, 8'h00});
    t_point(7, 4, 0); t_read(d, v);
    chk("R11 no alias", d, 8'h20);
    t_point(7, 25, 45); t_byte(8'h66);
    t_point(7, 25, 39); t_read(d, v);
    chk("R11 col oob", d, 8'h20);

    // R5 / R6 write stream across a row boundary
    t_point(3, 5, 38);
    for (int k = 0; k < 4; k++) t_byte(8'(8'h40 + k));
    chk("R6 row advance", {act_row, act_col}, {5'd6, 6'd2});
    t_point(3, 5, 38);
    for (int k = 0; k < 4; k++) begin
      t_read(d, v);
      chk("R5 readback", {v, d}, {1'b1, 8'(8'h40 + k)});
    end
    t_point(3, 5, 37); t_read(d, v);
    chk("R5 neighbour", d, 8'h20);
    t_point(2, 10, 0); t_byte(8'hA5);
    t_point(2, 10, 0); t_read(d, v);
    chk("R5 chapter 2", d, 8'hA5);

    // R7 status selection
    t_start(); t_byte(8'h00); t_byte(8'h01);
    t_point(3, 5, 38);
    for (int s = 0; s < 8; s++) begin
      sync_ok = s[0]; data_ok = s[1]; hz60 = s[2];
      t_read(d, v);
      chk("R7 status byte", {v, d}, {1'b1, s[2], 5'b0, s[1], s[0]});
    end
    chk("R7 pointer still", {act_row, act_col}, {5'd5, 6'd38});
    t_byte(8'h77);
    t_start(); t_byte(8'h00); t_byte(8'h00);
    t_point(3, 5, 38); t_read(d, v);
    chk("R7 write hits memory", d, 8'h77);

    // R10 non-data read
    t_start(); t_byte(8'h04); t_read(d, v);
    chk("R10 other sub read", {v, d}, {1'b1, 8'h00});

    // R8 clear chapter 2, R9 traffic during busy
    t_start(); t_byte(8'h08); t_byte(8'h0A);
    chk("R8 busy set", busy, 1);
    t_start(); t_byte(8'h04); t_byte(8'h05); t_read(d, v);
    chk("R9 no read while busy", v, 0);
    cnt = 4;
    while (busy && cnt < 5000) begin cnt++; @(negedge clk); end
    chk("R8 clear busy cycles", cnt, 1040);
    chk("R9 reg untouched", disp_chap, 7);
    chk("R8 chap kept, no vps", {vps_en, act_chap}, {1'b0, 3'd2});
    t_point(2, 10, 0); t_read(d, v);
    chk("R8 cleared byte", d, 8'h20);
    t_point(3, 5, 38); t_read(d, v);
    chk("R8 other chapter", d, 8'h77);
    t_point(0, 0, 7); t_read(d, v);
    chk("R8 chapter 0 kept", d, 8'h07);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule